// File: doc/BRIEF.md
# Banked Memory View Address Translator

This block sits between a set of processing-element ports and a memory that is interleaved over a power-of-two number of banks. Consecutive elements go to consecutive banks. Each port presents a logical access into a view of that memory. The block turns the access into the physical element number, then into a bank number and an address inside that bank. It also tells the bank crossbar which port targets which bank.

All ports share one view mode and one view argument per cycle. The argument is a factor or an offset, depending on the mode. Five views are supported:

- **Direct:** plain access.
- **Shrink:** the array is seen with fewer effective banks.
- **Aligned suffix:** the offset is a whole number of bank rows.
- **Shift:** the offset is arbitrary.
- **Split:** a one-dimensional array is seen as two-dimensional.

For every port the block reports whether its bank is fixed at compile time for that view, and whether the element lies outside the memory. All results appear one clock after the request.

Top module: `view_addr_xlat`

## Requirements
- R1: With mode code 0 (direct), the element is x = col. The bank is x mod BANKS, and the in-bank offset is x / BANKS.
- R2: With mode code 1 (shrink by factor s = arg), the element is x = col, split into bank and offset as in R1. A lane using columns p, p+BANKS/s, ... therefore alternates among banks p, p+BANKS/s, .... The fixed flag is high only when s is 0 or 1.
- R3: With mode code 2 (aligned suffix by e = arg), the element is x = BANKS*e + col. The bank equals col mod BANKS.
- R4: With mode code 3 (shift by e = arg), the element is x = e + col, and the fixed flag is low.
- R5: With mode code 4 (split by k = arg), an access at row j = row and column i = col reaches element x = k*i + j.
- R6: The fixed flag is high on every valid response in modes 0, 2 and 4.
- R7: When x >= DEPTH, the out-of-range flag is high, bank and offset read 0, and the port appears in no bank's routing mask.
- R8: A request gives its response exactly one cycle later. A port whose request valid was low responds with valid low and every other field at 0.
- R9: Bit [b][p] of the registered routing mask is high exactly when port p has a valid, in-range response with bank b.
- R10: Mode codes 5, 6 and 7 are reserved. They give no valid response on any port and an all-zero routing mask.
- R11: Synchronous active-high reset clears every output in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | PORTS | Per-port request valid |
| req_col | input | PORTS x IDX_W | Per-port view index (column i) |
| req_row | input | PORTS x IDX_W | Per-port row j, used by split mode only |
| view_mode | input | 3 | View kind code (0 direct, 1 shrink, 2 suffix, 3 shift, 4 split) |
| view_arg | input | IDX_W | Shrink factor, suffix row count, shift offset or split factor |
| rsp_valid | output | PORTS | Per-port response valid |
| rsp_bank | output | PORTS x BANK_W | Physical bank number |
| rsp_off | output | PORTS x OFF_W | Address inside the bank |
| rsp_fixed | output | PORTS | Bank is fixed at compile time for this view |
| rsp_oor | output | PORTS | Mapped element lies outside the memory |
| bank_sel | output | BANKS x PORTS | Crossbar routing mask, one row per bank |

## Verification
The hardest case to reach from the ports is the edge of the memory. A shift or split view must place some ports just below DEPTH and neighbouring ports at or just above it in the same cycle. The out-of-range zeroing and the routing mask then differ from port to port. Random offsets over an 8-bit argument seldom land there. The stimulus therefore includes directed cycles where the shift offset is DEPTH minus 2, with columns straddling the boundary. The random phase also biases arguments and columns toward small values, so most accesses stay in range and still wrap across banks.

// File: rtl/view_xlat_pkg.sv
package view_xlat_pkg;

    typedef enum logic [2:0] {
        VM_DIRECT = 3'd0,
        VM_SHRINK = 3'd1,
        VM_SUFFIX = 3'd2,
        VM_SHIFT  = 3'd3,
        VM_SPLIT  = 3'd4
    } view_mode_e;

    // Mode codes above VM_SPLIT are reserved.
    function automatic logic mode_known(input logic [2:0] m);
        return m <= 3'(VM_SPLIT);
    endfunction

    // Whether a lane's bank is known at compile time for a given view.
    function automatic logic mode_fixed(input logic [2:0] m, input logic arg_le1);
        logic f;
        case (m)
            3'(VM_DIRECT), 3'(VM_SUFFIX), 3'(VM_SPLIT): f = 1'b1;
            3'(VM_SHRINK):                               f = arg_le1;
            default:                                     f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/view_elem_map.sv
module view_elem_map
    import view_xlat_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int ELEM_W     = 17,
    parameter int LOG2_BANKS = 2
) (
    input  logic [2:0]        mode,
    input  logic [IDX_W-1:0]  arg,
    input  logic [IDX_W-1:0]  col,
    input  logic [IDX_W-1:0]  row,
    output logic [ELEM_W-1:0] elem,
    output logic              fixed,
    output logic              known
);
    logic [ELEM_W-1:0] arg_w;
    logic [ELEM_W-1:0] col_w;
    logic [ELEM_W-1:0] row_w;

    assign arg_w = ELEM_W'(arg);
    assign col_w = ELEM_W'(col);
    assign row_w = ELEM_W'(row);

    always_comb begin
        case (mode)
            3'(VM_DIRECT), 3'(VM_SHRINK): elem = col_w;
            3'(VM_SUFFIX): elem = (arg_w << LOG2_BANKS) + col_w;
            3'(VM_SHIFT):  elem = arg_w + col_w;
            3'(VM_SPLIT):  elem = (arg_w * col_w) + row_w;
            default:       elem = '0;
        endcase
    end

    assign known = mode_known(mode);
    assign fixed = mode_fixed(mode, arg <= IDX_W'(1));

endmodule

// File: rtl/elem_bank_split.sv
module elem_bank_split #(
    parameter int ELEM_W = 17,
    parameter int BANK_W = 2,
    parameter int OFF_W  = 4,
    parameter int DEPTH  = 64
) (
    input  logic [ELEM_W-1:0] elem,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  off,
    output logic              oor
);
    localparam logic [ELEM_W-1:0] LIMIT = ELEM_W'(DEPTH);

    assign oor  = elem >= LIMIT;
    assign bank = oor ? '0 : elem[BANK_W-1:0];
    assign off  = oor ? '0 : elem[BANK_W +: OFF_W];

endmodule

// File: rtl/bank_route_mask.sv
module bank_route_mask #(
    parameter int PORTS  = 4,
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  logic [PORTS-1:0]             hit,
    input  logic [PORTS-1:0][BANK_W-1:0] bank,
    output logic [BANKS-1:0][PORTS-1:0]  mask
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            assign mask[b][p] = hit[p] && (bank[p] == BANK_W'(b));
        end
    end

endmodule

// File: rtl/view_addr_xlat.sv
module view_addr_xlat #(
    parameter int PORTS  = 4,
    parameter int BANKS  = 4,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 8,
    parameter int BANK_W = $clog2(BANKS),
    parameter int OFF_W  = $clog2(DEPTH / BANKS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [PORTS-1:0]                req_valid,
    input  logic [PORTS-1:0][IDX_W-1:0]     req_col,
    input  logic [PORTS-1:0][IDX_W-1:0]     req_row,
    input  logic [2:0]                      view_mode,
    input  logic [IDX_W-1:0]                view_arg,
    output logic [PORTS-1:0]                rsp_valid,
    output logic [PORTS-1:0][BANK_W-1:0]    rsp_bank,
    output logic [PORTS-1:0][OFF_W-1:0]     rsp_off,
    output logic [PORTS-1:0]                rsp_fixed,
    output logic [PORTS-1:0]                rsp_oor,
    output logic [BANKS-1:0][PORTS-1:0]     bank_sel
);
    // BANKS must be a power of two (2 or more); DEPTH a multiple of BANKS.
    localparam int ELEM_W = 2 * IDX_W + 1;

    logic [PORTS-1:0]              nx_valid;
    logic [PORTS-1:0][BANK_W-1:0]  nx_bank;
    logic [PORTS-1:0][OFF_W-1:0]   nx_off;
    logic [PORTS-1:0]              nx_fixed;
    logic [PORTS-1:0]              nx_oor;
    logic [PORTS-1:0]              nx_hit;
    logic [BANKS-1:0][PORTS-1:0]   nx_sel;

    for (genvar p = 0; p < PORTS; p++) begin : g_lane
        logic [ELEM_W-1:0] elem;
        logic              fixed_raw;
        logic              known;
        logic [BANK_W-1:0] bank_raw;
        logic [OFF_W-1:0]  off_raw;
        logic              oor_raw;

        view_elem_map #(
            .IDX_W      (IDX_W),
            .ELEM_W     (ELEM_W),
            .LOG2_BANKS (BANK_W)
        ) map_i (
            .mode  (view_mode),
            .arg   (view_arg),
            .col   (req_col[p]),
            .row   (req_row[p]),
            .elem  (elem),
            .fixed (fixed_raw),
            .known (known)
        );

        elem_bank_split #(
            .ELEM_W (ELEM_W),
            .BANK_W (BANK_W),
            .OFF_W  (OFF_W),
            .DEPTH  (DEPTH)
        ) split_i (
            .elem (elem),
            .bank (bank_raw),
            .off  (off_raw),
            .oor  (oor_raw)
        );

        assign nx_valid[p] = req_valid[p] && known;
        assign nx_bank[p]  = nx_valid[p] ? bank_raw : '0;
        assign nx_off[p]   = nx_valid[p] ? off_raw  : '0;
        assign nx_fixed[p] = nx_valid[p] && fixed_raw;
        assign nx_oor[p]   = nx_valid[p] && oor_raw;
        assign nx_hit[p]   = nx_valid[p] && !oor_raw;
    end

    bank_route_mask #(
        .PORTS  (PORTS),
        .BANKS  (BANKS),
        .BANK_W (BANK_W)
    ) route_i (
        .hit  (nx_hit),
        .bank (nx_bank),
        .mask (nx_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_bank  <= '0;
            rsp_off   <= '0;
            rsp_fixed <= '0;
            rsp_oor   <= '0;
            bank_sel  <= '0;
        end else begin
            rsp_valid <= nx_valid;
            rsp_bank  <= nx_bank;
            rsp_off   <= nx_off;
            rsp_fixed <= nx_fixed;
            rsp_oor   <= nx_oor;
            bank_sel  <= nx_sel;
        end
    end

endmodule

// File: rtl/view_xlat_checker.sv
module view_xlat_checker #(
    parameter int PORTS  = 4,
    parameter int BANKS  = 4,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 8,
    parameter int BANK_W = 2,
    parameter int OFF_W  = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [PORTS-1:0]             req_valid,
    input logic [PORTS-1:0][IDX_W-1:0]  req_col,
    input logic [PORTS-1:0][IDX_W-1:0]  req_row,
    input logic [2:0]                   view_mode,
    input logic [IDX_W-1:0]             view_arg,
    input logic [PORTS-1:0]             rsp_valid,
    input logic [PORTS-1:0][BANK_W-1:0] rsp_bank,
    input logic [PORTS-1:0][OFF_W-1:0]  rsp_off,
    input logic [PORTS-1:0]             rsp_fixed,
    input logic [PORTS-1:0]             rsp_oor,
    input logic [BANKS-1:0][PORTS-1:0]  bank_sel
);
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (rsp_valid == '0 && bank_sel == '0));

    p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(view_mode) > 3'd4) |-> (rsp_valid == '0 && bank_sel == '0));

    for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
        p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
            !rsp_valid[p] |-> (rsp_bank[p] == '0 && rsp_off[p] == '0
                               && !rsp_fixed[p] && !rsp_oor[p]));

        p_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> $past(req_valid[p]));

        p_oor_zero_r7: assert property (@(posedge clk) disable iff (rst)
            rsp_oor[p] |-> (rsp_bank[p] == '0 && rsp_off[p] == '0));

        p_shift_unfixed_r4: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[p] && $past(view_mode) == 3'd3) |-> !rsp_fixed[p]);

        p_suffix_bank_r3: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[p] && !rsp_oor[p] && $past(view_mode) == 3'd2)
            |-> (rsp_bank[p] == $past(req_col[p][BANK_W-1:0])));

        for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
            p_route_match_r9: assert property (@(posedge clk) disable iff (rst)
                bank_sel[b][p] |-> (rsp_valid[p] && !rsp_oor[p]
                                    && rsp_bank[p] == BANK_W'(b)));
        end
    end

endmodule

bind view_addr_xlat view_xlat_checker #(
    .PORTS  (PORTS),
    .BANKS  (BANKS),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .BANK_W (BANK_W),
    .OFF_W  (OFF_W)
) chk_i (.*);

// File: tb/view_addr_xlat_tb_top.sv
module view_addr_xlat_tb_top;
    localparam int P  = 4;
    localparam int N  = 4;
    localparam int M  = 64;
    localparam int IW = 8;
    localparam int BW = 2;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [P-1:0]         req_valid = '0;
    logic [P-1:0][IW-1:0] req_col   = '0;
    logic [P-1:0][IW-1:0] req_row   = '0;
    logic [2:0]           view_mode = '0;
    logic [IW-1:0]        view_arg  = '0;
    logic [P-1:0]         rsp_valid;
    logic [P-1:0][BW-1:0] rsp_bank;
    logic [P-1:0][OW-1:0] rsp_off;
    logic [P-1:0]         rsp_fixed;
    logic [P-1:0]         rsp_oor;
    logic [N-1:0][P-1:0]  bank_sel;

    always #4 clk = ~clk;

    view_addr_xlat #(.PORTS(P), .BANKS(N), .DEPTH(M), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_col(req_col),
        .req_row(req_row), .view_mode(view_mode), .view_arg(view_arg),
        .rsp_valid(rsp_valid), .rsp_bank(rsp_bank), .rsp_off(rsp_off),
        .rsp_fixed(rsp_fixed), .rsp_oor(rsp_oor), .bank_sel(bank_sel));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected response for the request driven one cycle earlier.
    bit    e_valid[P];
    int    e_bank[P];
    int    e_off[P];
    bit    e_fixed[P];
    bit    e_oor[P];
    string e_tag[P];
    logic [N-1:0][P-1:0] e_sel;

    task automatic clear_expect();
        for (int p = 0; p < P; p++) begin
            e_valid[p] = 0; e_bank[p] = 0; e_off[p] = 0;
            e_fixed[p] = 0; e_oor[p] = 0; e_tag[p] = "R11";
        end
        e_sel = '0;
    endtask

    task automatic compare_now();
        for (int p = 0; p < P; p++) begin
            checks++;
            if (rsp_valid[p] !== e_valid[p] || int'(rsp_bank[p]) != e_bank[p] ||
                int'(rsp_off[p]) != e_off[p] || rsp_fixed[p] !== e_fixed[p] ||
                rsp_oor[p] !== e_oor[p]) begin
                fails++;
                $display("FAIL %s port %0d: got v=%0b b=%0d o=%0d f=%0b r=%0b exp v=%0b b=%0d o=%0d f=%0b r=%0b",
                         e_tag[p], p, rsp_valid[p], rsp_bank[p], rsp_off[p],
                         rsp_fixed[p], rsp_oor[p], e_valid[p], e_bank[p],
                         e_off[p], e_fixed[p], e_oor[p]);
            end
        end
        checks++;
        if (bank_sel !== e_sel) begin
            fails++;
            $display("FAIL R9 routing mask: got %h exp %h", bank_sel, e_sel);
        end
    endtask

    // Reference model: computes the expected response from the requirements.
    task automatic model(input int mode, input int arg);
        e_sel = '0;
        for (int p = 0; p < P; p++) begin
            int x;
            int col = int'(req_col[p]);
            int row = int'(req_row[p]);
            case (mode)
                0, 1:    x = col;
                2:       x = N * arg + col;
                3:       x = arg + col;
                4:       x = arg * col + row;
                default: x = 0;
            endcase
            e_valid[p] = req_valid[p] && (mode <= 4);
            e_bank[p] = 0; e_off[p] = 0; e_fixed[p] = 0; e_oor[p] = 0;
            if (mode > 4)            e_tag[p] = "R10";
            else if (!req_valid[p])  e_tag[p] = "R8";
            else if (x >= M)         e_tag[p] = "R7";
            else case (mode)
                0: e_tag[p] = "R1/R6";
                1: e_tag[p] = "R2";
                2: e_tag[p] = "R3/R6";
                3: e_tag[p] = "R4";
                default: e_tag[p] = "R5/R6";
            endcase
            if (e_valid[p]) begin
                e_oor[p]   = (x >= M);
                e_fixed[p] = (mode == 0 || mode == 2 || mode == 4 || (mode == 1 && arg <= 1));
                if (!e_oor[p]) begin
                    e_bank[p] = x % N;
                    e_off[p]  = x / N;
                    e_sel[e_bank[p]][p] = 1'b1;
                end
            end
        end
    endtask

    // Check the previous request's response, then drive and model a new one.
    task automatic step(input int mode, input int arg, input logic [P-1:0] vld,
                        input int c0, input int c1, input int c2, input int c3,
                        input int r0, input int r1, input int r2, input int r3);
        @(negedge clk);
        compare_now();
        view_mode = 3'(mode);
        view_arg  = IW'(arg);
        req_valid = vld;
        req_col[0] = IW'(c0); req_col[1] = IW'(c1);
        req_col[2] = IW'(c2); req_col[3] = IW'(c3);
        req_row[0] = IW'(r0); req_row[1] = IW'(r1);
        req_row[2] = IW'(r2); req_row[3] = IW'(r3);
        model(mode, arg);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_expect();
        // R11: outputs cleared under reset, even with a live request present.
        req_valid = '1; req_col[0] = 8'd5; view_mode = 3'd3;
        repeat (3) @(negedge clk);
        compare_now();
        @(negedge clk);
        rst = 1'b0;
        model(3, 0);

        // R1: direct view across two bank rows.
        step(0, 0, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        step(0, 0, 4'hF, 4, 5, 6, 7, 0, 0, 0, 0);
        // R2: shrink by 2 (lanes alternate among banks p, p+2) and by 1.
        step(1, 2, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        step(1, 2, 4'hF, 2, 3, 4, 5, 0, 0, 0, 0);
        step(1, 1, 4'hF, 9, 10, 11, 12, 0, 0, 0, 0);
        // R3: aligned suffix, bank unchanged, offset moved.
        step(2, 3, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        step(2, 15, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        // R4: shift by an unaligned offset, bank rotates.
        step(3, 5, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        // R5: split 12 elements by 2 into a 2x6 view.
        step(4, 2, 4'hF, 0, 1, 5, 3, 0, 1, 1, 0);
        // R7: shift straddling the end of memory.
        step(3, M - 2, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        step(2, 16, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        // R8: partial request valid.
        step(0, 0, 4'b0101, 8, 9, 10, 11, 0, 0, 0, 0);
        step(0, 0, 4'b0000, 8, 9, 10, 11, 0, 0, 0, 0);
        // R10: reserved codes.
        for (int m = 5; m < 8; m++) step(m, 1, 4'hF, 0, 1, 2, 3, 0, 0, 0, 0);
        // R9: several ports on one bank.
        step(0, 0, 4'hF, 1, 5, 9, 13, 0, 0, 0, 0);

        // Random phase over all modes, small arguments favoured.
        for (int t = 0; t < 4000; t++) begin
            int mode = ($urandom % 10 == 0) ? (5 + int'($urandom % 3)) : int'($urandom % 5);
            int arg  = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 20);
            int lim  = ($urandom % 4 == 0) ? 256 : 40;
            logic [P-1:0] vld = ($urandom % 5 == 0) ? P'($urandom) : '1;
            step(mode, arg, vld,
                 int'($urandom % lim), int'($urandom % lim),
                 int'($urandom % lim), int'($urandom % lim),
                 int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 8), int'($urandom % 8));
        end
        @(negedge clk);
        compare_now();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule